// File: doc/BRIEF.md
# Dual-Stage Operand Input Pipeline

This block prepares two signed operands, a 34-bit operand A and a 24-bit operand B, on their way into a multiply-accumulate slice. For each operand a static parameter picks the source. The source is either the slice's own direct port or the cascade bus from the neighbouring slice in the same column. The chosen value then passes through zero, one or two register stages, and a static depth parameter sets that count. Each register has its own clock enable and its own synchronous clear.

Three kinds of result leave the block. The multiplier operand for A and for B is picked on every cycle by a dynamic select bit: either the first-stage register or the final-stage value of that operand. The cascade outputs have their own static stage count, which may not exceed the main depth, and they feed the next slice. The adder-path operand is the 58-bit concatenation of the final-stage A and B values. The multiplier, the pre-adder and the ALU sit outside this block.

Top module: `opnd_in_pipe`

## Requirements
- R1: When the source parameter of an operand is 1, that operand takes its cascade input. When it is 0, it takes its direct port.
- R2: With a depth of 0, the final-stage value equals the selected input in the same cycle, with no register in the path.
- R3: With a depth of 1, a single register sits in the final path. The final-stage value shows the selected input from the last clock edge at which that register was enabled.
- R4: With a depth of 2, two registers sit in series. The second register loads the first register's value, so the input appears after two enabled edges.
- R5: A high synchronous reset clears its own register stage to zero at the next clock edge. The reset wins over that stage's clock enable.
- R6: A register whose clock enable is low and whose reset is low keeps its value, whatever the inputs do.
- R7: When `selAFirst` is 1, `mulA` carries the A first-stage register. When it is 0, `mulA` carries the A final-stage value. The select acts in the same cycle.
- R8: When `selBFirst` is 1, `mulB` carries the B first-stage register. When it is 0, `mulB` carries the B final-stage value. The select acts in the same cycle.
- R9: Each cascade output has its own stage count. A count of 0 gives the selected input. A count of 1 gives the first register of the chain, which is the only register at depth 1. A count of 2 gives the second register. A count above the main depth, or a depth above 2, stops elaboration.
- R10: `adderOp` equals final-stage A in bits 57:24 and final-stage B in bits 23:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all register stages |
| aDirect | input | 34 | Direct operand A |
| aCascIn | input | 34 | Operand A cascade from the adjacent slice |
| bDirect | input | 24 | Direct operand B |
| bCascIn | input | 24 | Operand B cascade from the adjacent slice |
| ceA1 | input | 1 | Clock enable, A first stage |
| ceA2 | input | 1 | Clock enable, A second stage |
| ceB1 | input | 1 | Clock enable, B first stage |
| ceB2 | input | 1 | Clock enable, B second stage |
| rstA1 | input | 1 | Synchronous clear, A first stage |
| rstA2 | input | 1 | Synchronous clear, A second stage |
| rstB1 | input | 1 | Synchronous clear, B first stage |
| rstB2 | input | 1 | Synchronous clear, B second stage |
| selAFirst | input | 1 | 1: multiplier A from first stage; 0: from final stage |
| selBFirst | input | 1 | 1: multiplier B from first stage; 0: from final stage |
| mulA | output | 34 | Operand A toward the multiplier |
| mulB | output | 24 | Operand B toward the multiplier |
| aCascOut | output | 34 | Operand A cascade toward the next slice |
| bCascOut | output | 24 | Operand B cascade toward the next slice |
| adderOp | output | 58 | Concatenated A:B operand for the adder path |

## Verification
The assertions assume that every control and data input holds a defined level at each rising edge. They also assume that checking only starts once a first edge has passed, because a register's load, hold and clear are judged from the input seen one edge earlier. The bench meets both conditions. It drives every input on the falling edge, from a fixed-seed random stream or from directed values, and never leaves an input undriven. It also opens with one edge where all clears are high. The random stream keeps clears rare and enables mostly high, so long load chains and hold periods both occur. Two instances with different depth, cascade-count and source settings cover the 0, 1 and 2 stage paths.

// File: rtl/opnd_pipe_pkg.sv
package opnd_pipe_pkg;

  // per-lane register strobes
  typedef struct packed {
    logic ce1;
    logic ce2;
    logic rst1;
    logic rst2;
  } laneStrobe_t;

  // bundle handed from control to datapath
  typedef struct packed {
    laneStrobe_t a;
    laneStrobe_t b;
    logic        aFirst;
    logic        bFirst;
  } pipeStrobe_t;

endpackage

// File: rtl/opnd_pipe_ctrl.sv
module opnd_pipe_ctrl
  import opnd_pipe_pkg::*;
(
  input  logic        ceA1,
  input  logic        ceA2,
  input  logic        ceB1,
  input  logic        ceB2,
  input  logic        rstA1,
  input  logic        rstA2,
  input  logic        rstB1,
  input  logic        rstB2,
  input  logic        selAFirst,
  input  logic        selBFirst,
  output pipeStrobe_t strobes
);

  always_comb begin
    strobes.a.ce1  = ceA1;
    strobes.a.ce2  = ceA2;
    strobes.a.rst1 = rstA1;
    strobes.a.rst2 = rstA2;
    strobes.b.ce1  = ceB1;
    strobes.b.ce2  = ceB2;
    strobes.b.rst1 = rstB1;
    strobes.b.rst2 = rstB2;
    strobes.aFirst = selAFirst;
    strobes.bFirst = selBFirst;
  end

endmodule

// File: rtl/opnd_pipe_lane.sv
module opnd_pipe_lane
  import opnd_pipe_pkg::*;
#(
  parameter int W          = 34,
  parameter int DEPTH      = 2,
  parameter int CASC_DEPTH = 1,
  parameter bit FROM_CASC  = 1'b0
) (
  input  logic        clk,
  input  logic [W-1:0] directIn,
  input  logic [W-1:0] cascIn,
  input  laneStrobe_t strobe,
  input  logic        selFirst,
  output logic [W-1:0] mulOp,
  output logic [W-1:0] finalOp,
  output logic [W-1:0] cascOut
);

  // elaboration guard on the static configuration (R9)
  if (DEPTH > 2 || CASC_DEPTH > DEPTH) begin : gBadCfg
    $error("opnd_pipe_lane: cascade count above depth or depth above 2");
  end

  logic [W-1:0] laneIn;
  logic [W-1:0] stage1;

  // static source choice (R1)
  if (FROM_CASC) begin : gSrcCasc
    assign laneIn = cascIn;
  end else begin : gSrcDirect
    assign laneIn = directIn;
  end

  // first-stage register, always present for the multiplier select
  always_ff @(posedge clk) begin
    if (strobe.rst1)     stage1 <= '0;
    else if (strobe.ce1) stage1 <= laneIn;
  end

  if (DEPTH == 0) begin : gDepth0
    logic unusedStage2;
    assign unusedStage2 = strobe.ce2 ^ strobe.rst2;
    assign finalOp = laneIn;
    assign cascOut = laneIn;
  end else begin : gDepthReg
    logic [W-1:0] stage2;
    logic [W-1:0] stage2D;

    if (DEPTH == 2) begin : gChain
      assign stage2D = stage1;
    end else begin : gSingle
      assign stage2D = laneIn;
    end

    always_ff @(posedge clk) begin
      if (strobe.rst2)     stage2 <= '0;
      else if (strobe.ce2) stage2 <= stage2D;
    end

    assign finalOp = stage2;

    if (CASC_DEPTH == 0) begin : gCasc0
      assign cascOut = laneIn;
    end else if (CASC_DEPTH == 1 && DEPTH == 2) begin : gCascMid
      assign cascOut = stage1;
    end else begin : gCascLast
      assign cascOut = stage2;
    end
  end

  assign mulOp = selFirst ? stage1 : finalOp;

  // ---------------- assertions ----------------
  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= 1'b1;

  assert_stage1_clear_R5: assert property (@(posedge clk) disable iff (!primed)
    strobe.rst1 |=> (!selFirst || mulOp == '0));

  assert_stage1_hold_R6: assert property (@(posedge clk) disable iff (!primed)
    (!strobe.rst1 && !strobe.ce1) |=> $stable(stage1));

  assert_stage1_load_R7: assert property (@(posedge clk) disable iff (!primed)
    (strobe.ce1 && !strobe.rst1) |=> (stage1 == $past(laneIn)));

  if (DEPTH == 1) begin : gChkD1
    assert_single_stage_R3: assert property (@(posedge clk) disable iff (!primed)
      (strobe.ce2 && !strobe.rst2) |=> (finalOp == $past(laneIn)));
  end

  if (DEPTH == 2) begin : gChkD2
    assert_chain_stage_R4: assert property (@(posedge clk) disable iff (!primed)
      (strobe.ce2 && !strobe.rst2) |=> (finalOp == $past(stage1)));
  end

  if (DEPTH >= 1) begin : gChkRst2
    assert_stage2_clear_R5: assert property (@(posedge clk) disable iff (!primed)
      strobe.rst2 |=> (finalOp == '0));
  end

endmodule

// File: rtl/opnd_pipe_dp.sv
module opnd_pipe_dp
  import opnd_pipe_pkg::*;
#(
  parameter int A_W          = 34,
  parameter int B_W          = 24,
  parameter int A_DEPTH      = 2,
  parameter int B_DEPTH      = 2,
  parameter int A_CASC_DEPTH = 1,
  parameter int B_CASC_DEPTH = 1,
  parameter bit A_FROM_CASC  = 1'b0,
  parameter bit B_FROM_CASC  = 1'b0,
  localparam int SUM_W       = A_W + B_W
) (
  input  logic             clk,
  input  logic [A_W-1:0]   aDirect,
  input  logic [A_W-1:0]   aCascIn,
  input  logic [B_W-1:0]   bDirect,
  input  logic [B_W-1:0]   bCascIn,
  input  pipeStrobe_t      strobes,
  output logic [A_W-1:0]   mulA,
  output logic [B_W-1:0]   mulB,
  output logic [A_W-1:0]   aCascOut,
  output logic [B_W-1:0]   bCascOut,
  output logic [SUM_W-1:0] adderOp
);

  logic [A_W-1:0] aFinal;
  logic [B_W-1:0] bFinal;

  opnd_pipe_lane #(
    .W(A_W), .DEPTH(A_DEPTH), .CASC_DEPTH(A_CASC_DEPTH), .FROM_CASC(A_FROM_CASC)
  ) uLaneA (
    .clk      (clk),
    .directIn (aDirect),
    .cascIn   (aCascIn),
    .strobe   (strobes.a),
    .selFirst (strobes.aFirst),
    .mulOp    (mulA),
    .finalOp  (aFinal),
    .cascOut  (aCascOut)
  );

  opnd_pipe_lane #(
    .W(B_W), .DEPTH(B_DEPTH), .CASC_DEPTH(B_CASC_DEPTH), .FROM_CASC(B_FROM_CASC)
  ) uLaneB (
    .clk      (clk),
    .directIn (bDirect),
    .cascIn   (bCascIn),
    .strobe   (strobes.b),
    .selFirst (strobes.bFirst),
    .mulOp    (mulB),
    .finalOp  (bFinal),
    .cascOut  (bCascOut)
  );

  // adder-path operand: A high, B low (R10)
  assign adderOp = {aFinal, bFinal};

endmodule

// File: rtl/opnd_in_pipe.sv
module opnd_in_pipe
  import opnd_pipe_pkg::*;
#(
  parameter int A_W          = 34,
  parameter int B_W          = 24,
  parameter int A_DEPTH      = 2,
  parameter int B_DEPTH      = 2,
  parameter int A_CASC_DEPTH = 1,
  parameter int B_CASC_DEPTH = 1,
  parameter bit A_FROM_CASC  = 1'b0,
  parameter bit B_FROM_CASC  = 1'b0,
  localparam int SUM_W       = A_W + B_W
) (
  input  logic             clk,
  input  logic [A_W-1:0]   aDirect,
  input  logic [A_W-1:0]   aCascIn,
  input  logic [B_W-1:0]   bDirect,
  input  logic [B_W-1:0]   bCascIn,
  input  logic             ceA1,
  input  logic             ceA2,
  input  logic             ceB1,
  input  logic             ceB2,
  input  logic             rstA1,
  input  logic             rstA2,
  input  logic             rstB1,
  input  logic             rstB2,
  input  logic             selAFirst,
  input  logic             selBFirst,
  output logic [A_W-1:0]   mulA,
  output logic [B_W-1:0]   mulB,
  output logic [A_W-1:0]   aCascOut,
  output logic [B_W-1:0]   bCascOut,
  output logic [SUM_W-1:0] adderOp
);

  pipeStrobe_t strobes;

  opnd_pipe_ctrl uCtrl (
    .ceA1      (ceA1),
    .ceA2      (ceA2),
    .ceB1      (ceB1),
    .ceB2      (ceB2),
    .rstA1     (rstA1),
    .rstA2     (rstA2),
    .rstB1     (rstB1),
    .rstB2     (rstB2),
    .selAFirst (selAFirst),
    .selBFirst (selBFirst),
    .strobes   (strobes)
  );

  opnd_pipe_dp #(
    .A_W(A_W), .B_W(B_W),
    .A_DEPTH(A_DEPTH), .B_DEPTH(B_DEPTH),
    .A_CASC_DEPTH(A_CASC_DEPTH), .B_CASC_DEPTH(B_CASC_DEPTH),
    .A_FROM_CASC(A_FROM_CASC), .B_FROM_CASC(B_FROM_CASC)
  ) uDp (
    .clk      (clk),
    .aDirect  (aDirect),
    .aCascIn  (aCascIn),
    .bDirect  (bDirect),
    .bCascIn  (bCascIn),
    .strobes  (strobes),
    .mulA     (mulA),
    .mulB     (mulB),
    .aCascOut (aCascOut),
    .bCascOut (bCascOut),
    .adderOp  (adderOp)
  );

endmodule

// File: tb/sim_opnd_in_pipe.sv
module sim_opnd_in_pipe;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [33:0] aDir, aCas;
  logic [23:0] bDir, bCas;
  logic ceA1, ceA2, ceB1, ceB2, rstA1, rstA2, rstB1, rstB2, selA, selB;

  logic [33:0] mulA0, aCo0, mulA1, aCo1;
  logic [23:0] mulB0, bCo0, mulB1, bCo1;
  logic [57:0] add0, add1;

  // u0: A depth 2 / casc 1 / direct ; B depth 1 / casc 1 / cascade
  opnd_in_pipe #(.A_DEPTH(2), .B_DEPTH(1), .A_CASC_DEPTH(1), .B_CASC_DEPTH(1),
                 .A_FROM_CASC(1'b0), .B_FROM_CASC(1'b1)) u0 (
    .clk(clk), .aDirect(aDir), .aCascIn(aCas), .bDirect(bDir), .bCascIn(bCas),
    .ceA1(ceA1), .ceA2(ceA2), .ceB1(ceB1), .ceB2(ceB2),
    .rstA1(rstA1), .rstA2(rstA2), .rstB1(rstB1), .rstB2(rstB2),
    .selAFirst(selA), .selBFirst(selB),
    .mulA(mulA0), .mulB(mulB0), .aCascOut(aCo0), .bCascOut(bCo0), .adderOp(add0));

  // u1: A depth 0 / casc 0 / cascade ; B depth 2 / casc 2 / direct
  opnd_in_pipe #(.A_DEPTH(0), .B_DEPTH(2), .A_CASC_DEPTH(0), .B_CASC_DEPTH(2),
                 .A_FROM_CASC(1'b1), .B_FROM_CASC(1'b0)) u1 (
    .clk(clk), .aDirect(aDir), .aCascIn(aCas), .bDirect(bDir), .bCascIn(bCas),
    .ceA1(ceA1), .ceA2(ceA2), .ceB1(ceB1), .ceB2(ceB2),
    .rstA1(rstA1), .rstA2(rstA2), .rstB1(rstB1), .rstB2(rstB2),
    .selAFirst(selA), .selBFirst(selB),
    .mulA(mulA1), .mulB(mulB1), .aCascOut(aCo1), .bCascOut(bCo1), .adderOp(add1));

  // lanes: 0 = u0.A, 1 = u0.B, 2 = u1.A, 3 = u1.B
  localparam int DEP[4] = '{2, 1, 0, 2};
  localparam int CAS[4] = '{1, 1, 0, 2};
  localparam int SRC[4] = '{0, 1, 1, 0};

  logic [33:0] m1[4];
  logic [33:0] m2[4];
  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  function automatic logic [33:0] laneIn(int i);
    if (i % 2 == 0) return (SRC[i] != 0) ? aCas : aDir;
    return {10'b0, ((SRC[i] != 0) ? bCas : bDir)};
  endfunction

  function automatic logic [33:0] finExp(int i);
    return (DEP[i] == 0) ? laneIn(i) : m2[i];
  endfunction

  function automatic logic [33:0] casExp(int i);
    if (CAS[i] == 0) return laneIn(i);
    if (CAS[i] == 1 && DEP[i] == 2) return m1[i];
    return m2[i];
  endfunction

  function automatic logic [33:0] mulExp(int i);
    logic s;
    s = (i % 2 == 0) ? selA : selB;
    return s ? m1[i] : finExp(i);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string pick(string tag, string dflt);
    return (tag == "") ? dflt : tag;
  endfunction

  task automatic checkAll(string tag);
    chk(pick(tag, "R7 u0"), 64'(mulA0), 64'(mulExp(0)));
    chk(pick(tag, "R8 u0"), 64'(mulB0), 64'(mulExp(1)));
    chk(pick(tag, "R9 u0 A"), 64'(aCo0), 64'(casExp(0)));
    chk(pick(tag, "R9 R1 u0 B"), 64'(bCo0), 64'(casExp(1)));
    chk(pick(tag, "R10 R4 R3 u0"), 64'(add0), 64'({finExp(0), finExp(1)[23:0]}));
    chk(pick(tag, "R7 R2 u1"), 64'(mulA1), 64'(mulExp(2)));
    chk(pick(tag, "R8 u1"), 64'(mulB1), 64'(mulExp(3)));
    chk(pick(tag, "R9 R1 u1 A"), 64'(aCo1), 64'(casExp(2)));
    chk(pick(tag, "R9 u1 B"), 64'(bCo1), 64'(casExp(3)));
    chk(pick(tag, "R10 R1 R2 R4 u1"), 64'(add1), 64'({finExp(2), finExp(3)[23:0]}));
  endtask

  task automatic updateModel();
    logic [33:0] n1[4];
    logic [33:0] n2[4];
    for (int i = 0; i < 4; i++) begin
      logic c1, c2, r1, r2;
      c1 = (i % 2 == 0) ? ceA1 : ceB1;
      c2 = (i % 2 == 0) ? ceA2 : ceB2;
      r1 = (i % 2 == 0) ? rstA1 : rstB1;
      r2 = (i % 2 == 0) ? rstA2 : rstB2;
      n1[i] = r1 ? 34'd0 : (c1 ? laneIn(i) : m1[i]);
      n2[i] = r2 ? 34'd0 : (c2 ? ((DEP[i] == 2) ? m1[i] : laneIn(i)) : m2[i]);
    end
    for (int i = 0; i < 4; i++) begin
      m1[i] = n1[i];
      m2[i] = n2[i];
    end
  endtask

  task automatic randData();
    aDir = {$urandom(), $urandom()} ;
    aCas = {$urandom(), $urandom()} ;
    bDir = 24'($urandom());
    bCas = 24'($urandom());
  endtask

  // checks happen mid-cycle, then the edge, then the model follows
  task automatic cycle(string tag);
    #1;
    checkAll(tag);
    @(posedge clk);
    updateModel();
    @(negedge clk);
  endtask

  task automatic setCtl(logic ce, logic rst);
    {ceA1, ceA2, ceB1, ceB2} = {4{ce}};
    {rstA1, rstA2, rstB1, rstB2} = {4{rst}};
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4; i++) begin m1[i] = '0; m2[i] = '0; end
    randData();
    selA = 1'b1; selB = 1'b1;
    setCtl(1'b1, 1'b1);
    @(posedge clk);
    updateModel();
    @(negedge clk);

    // R5: reset state, clear wins over enable
    randData();
    cycle("R5 reset state");
    selA = 1'b0; selB = 1'b0;
    randData();
    cycle("R5 reset state final");

    // load a known pattern through both stages
    setCtl(1'b1, 1'b0);
    aDir = 34'h2_AAAA_5555; aCas = 34'h1_0F0F_F0F0;
    bDir = 24'hC3C3C3;      bCas = 24'h3C3C3C;
    cycle("R1 R3 R4 load");
    cycle("R1 R3 R4 load");
    selA = 1'b1; selB = 1'b1;
    cycle("R7 R8 first stage");

    // R6: enables low, data moving, registers must hold
    setCtl(1'b0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      randData();
      selA = k[0]; selB = k[1];
      cycle("R6 hold");
    end

    // R5: clear asserted with enable high
    setCtl(1'b1, 1'b1);
    randData();
    cycle("R5 clear over enable");
    setCtl(1'b0, 1'b0);
    randData();
    cycle("R5 after clear");

    // extreme values
    setCtl(1'b1, 1'b0);
    aDir = '1; aCas = '1; bDir = '1; bCas = '1;
    cycle("");
    aDir = 34'h2_0000_0000; aCas = 34'h2_0000_0000; bDir = 24'h800000; bCas = 24'h800000;
    cycle("");
    cycle("");

    // constrained random
    for (int n = 0; n < 400; n++) begin
      randData();
      ceA1 = ($urandom() % 4) != 0;
      ceA2 = ($urandom() % 4) != 0;
      ceB1 = ($urandom() % 4) != 0;
      ceB2 = ($urandom() % 4) != 0;
      rstA1 = ($urandom() % 16) == 0;
      rstA2 = ($urandom() % 16) == 0;
      rstB1 = ($urandom() % 16) == 0;
      rstB2 = ($urandom() % 16) == 0;
      selA = $urandom() % 2;
      selB = $urandom() % 2;
      cycle("");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule